// File: doc/BRIEF.md
# Seconds Counter with Match Alarms

This block keeps time in whole seconds. A pulse on `sec_tick` advances an up counter by one and moves a companion down counter the other way by one. When software has loaded the two counters as complements, their sum stays at all-ones. Two match registers are compared against the up counter. An equal compare sets a sticky status flag. Software clears a flag by writing a 1 to its bit.

Software drives a simple register port: a one-cycle write strobe or read strobe, a byte offset, and write data. Read data is registered and appears on the cycle after the read strobe. It is zero in every other cycle. A control register holds the interrupt enables, the wake enables, a counter hold bit, a software clear bit and a wake force bit. Each status flag can drive the interrupt line, the wake output, or both. A key register keeps whatever software wrote into it across the synchronous reset. Start-up code can read it to learn whether the block was already set up.

Register offsets (bytes): 0x00 up counter, 0x04 down counter, 0x08 match slot 0, 0x0C match slot 1, 0x10 control, 0x14 status, 0x18 key.

Top module: `sec_alarm_ctr`

## Requirements
- R1: After `rst`, the following reset values hold.
  - The up counter is 0 and the down counter is 0xFFFFFFFF.
  - Both match registers are 0xFFFFFFFF.
  - Control and status read 0.
  - `irq_o` and `wake_o` are 0.
- R2: On a `sec_tick` cycle with no bus write, the up counter increments by one and the down counter decrements by one, provided control bit 6 (hold) and bit 4 (clear) are both 0.
- R3: While control bit 6 is 1, ticks leave both counters unchanged.
- R4: A bus write to a counter takes effect over a tick or a clear in the same cycle. The other counter still follows the tick.
- R5: Status bit 0 (slot 0) and bit 1 (slot 1) set one cycle after the up counter equals the slot's match value. The bit is set again on every cycle the equality holds, even across a clear write.
- R6: Writing 1 to a status bit at offset 0x14 clears it once the set condition is gone. Writing 0 leaves it unchanged.
- R7: `irq_o` is 1 one cycle after status bit 0 is set with control bit 0 set, or after status bit 1 is set with control bit 1 set.
- R8: With control bit 2 (slot 0) or bit 3 (slot 1) set and the matching status bit set, two things follow one cycle later.
  - `wake_o` goes high.
  - Status bit 2 latches; it is cleared by writing 1 to that bit.
- R9: Control bit 7 drives `wake_o` high one cycle later and does not set any status bit.
- R10: While control bit 4 is 1, both counters are forced to 0. Match, key and control registers keep their values.
- R11: The key register at 0x18 reads back the last value written and is not changed by `rst`.
- R12: Reads of unmapped offsets return 0, and writes to them change no register. Control bit 5 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake / power-on request |

## Verification
The counters are tried in three conditions:
- free ticking from a loaded value, which separates a correct increment and decrement pair from a stuck or one-sided counter;
- ticking while held, which shows that the hold bit gates both counters;
- a write that lands on a tick cycle, which shows that the write takes priority while the other counter still advances.

The match path is tried three ways:
- An alarm with only the interrupt enabled tests the irq path.
- An alarm with only the wake enabled shows that the two enables act independently.
- A clear written while the equality still holds must not stick, since the flag sets again.

The clear function, the forced wake, unmapped offsets and a reset with a key already written show which registers each action may and may not touch.

// File: rtl/sac_pkg.sv
package sac_pkg;
  localparam int N_MATCH = 2;

  localparam logic [7:0] OFS_UP   = 8'h00;
  localparam logic [7:0] OFS_DN   = 8'h04;
  localparam logic [7:0] OFS_M0   = 8'h08;
  localparam logic [7:0] OFS_CTRL = 8'h10;
  localparam logic [7:0] OFS_STAT = 8'h14;
  localparam logic [7:0] OFS_KEY  = 8'h18;

  localparam int CB_IE0   = 0;
  localparam int CB_OW0   = 2;
  localparam int CB_CLR   = 4;
  localparam int CB_HOLD  = 6;
  localparam int CB_FORCE = 7;

  localparam logic [7:0] CTRL_MASK = 8'hDF;
  localparam int SB_ONSW = 2;
endpackage

// File: rtl/sac_counter_pair.sv
module sac_counter_pair #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         halt,
  input  logic         clear,
  input  logic         wr_up,
  input  logic         wr_dn,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] up_q,
  output logic [W-1:0] dn_q
);
  logic step;
  assign step = tick && !halt;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q <= '0;
      dn_q <= '1;
    end else begin
      if (wr_up)      up_q <= wdata;
      else if (clear) up_q <= '0;
      else if (step)  up_q <= up_q + W'(1);

      if (wr_dn)      dn_q <= wdata;
      else if (clear) dn_q <= '0;
      else if (step)  dn_q <= dn_q - W'(1);
    end
  end
endmodule

// File: rtl/sac_match_slot.sv
module sac_match_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_val,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] count,
  input  logic         clr,
  output logic [W-1:0] val_q,
  output logic         flag_q
);
  logic hit;
  assign hit = (count == val_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q  <= '1;
      flag_q <= 1'b0;
    end else begin
      if (wr_val) val_q <= wdata;
      // set has priority: a flag whose equality still holds re-latches
      flag_q <= (flag_q && !clr) || hit;
    end
  end
endmodule

// File: rtl/sac_readmux.sv
module sac_readmux
  import sac_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic [W-1:0]                up,
  input  logic [W-1:0]                dn,
  input  logic [N_MATCH-1:0][W-1:0]   mval,
  input  logic [7:0]                  ctrl,
  input  logic [2:0]                  stat,
  input  logic [W-1:0]                key,
  output logic [W-1:0]                data
);
  always_comb begin
    data = '0;
    if (addr == ADDR_W'(OFS_UP))        data = up;
    else if (addr == ADDR_W'(OFS_DN))   data = dn;
    else if (addr == ADDR_W'(OFS_CTRL)) data = W'(ctrl);
    else if (addr == ADDR_W'(OFS_STAT)) data = W'(stat);
    else if (addr == ADDR_W'(OFS_KEY))  data = key;
    else begin
      for (int i = 0; i < N_MATCH; i++)
        if (addr == ADDR_W'(OFS_M0 + 8'(4 * i))) data = mval[i];
    end
  end
endmodule

// File: rtl/sec_alarm_ctr.sv
module sec_alarm_ctr
  import sac_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              irq_o,
  output logic              wake_o
);
  logic [7:0]                ctrl_q;
  logic [W-1:0]              up_cnt, dn_cnt;
  logic [N_MATCH-1:0][W-1:0] mval;
  logic [N_MATCH-1:0]        flags;
  logic                      onsw_q;
  logic [W-1:0]              key_q = '0;
  logic [W-1:0]              rd_mux;
  logic                      onsw_cond;
  logic                      wr_stat;

  assign wr_stat = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (bus_wr && bus_addr == ADDR_W'(OFS_CTRL))
      ctrl_q <= bus_wdata[7:0] & CTRL_MASK;
  end

  // key register: no reset, so it survives host resets
  always_ff @(posedge clk) begin
    if (bus_wr && bus_addr == ADDR_W'(OFS_KEY)) key_q <= bus_wdata;
  end

  sac_counter_pair #(.W(W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .tick  (sec_tick),
    .halt  (ctrl_q[CB_HOLD]),
    .clear (ctrl_q[CB_CLR]),
    .wr_up (bus_wr && bus_addr == ADDR_W'(OFS_UP)),
    .wr_dn (bus_wr && bus_addr == ADDR_W'(OFS_DN)),
    .wdata (bus_wdata),
    .up_q  (up_cnt),
    .dn_q  (dn_cnt)
  );

  for (genvar g = 0; g < N_MATCH; g++) begin : g_slot
    sac_match_slot #(.W(W)) u_slot (
      .clk    (clk),
      .rst    (rst),
      .wr_val (bus_wr && bus_addr == ADDR_W'(OFS_M0 + 8'(4 * g))),
      .wdata  (bus_wdata),
      .count  (up_cnt),
      .clr    (wr_stat && bus_wdata[g]),
      .val_q  (mval[g]),
      .flag_q (flags[g])
    );
  end

  assign onsw_cond = |(flags & ctrl_q[CB_OW0 +: N_MATCH]);

  always_ff @(posedge clk) begin
    if (rst) begin
      onsw_q <= 1'b0;
      irq_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      onsw_q <= (onsw_q && !(wr_stat && bus_wdata[SB_ONSW])) || onsw_cond;
      irq_o  <= |(flags & ctrl_q[CB_IE0 +: N_MATCH]);
      wake_o <= ctrl_q[CB_FORCE] || onsw_cond;
    end
  end

  sac_readmux #(.W(W), .ADDR_W(ADDR_W)) u_rmux (
    .addr (bus_addr),
    .up   (up_cnt),
    .dn   (dn_cnt),
    .mval (mval),
    .ctrl (ctrl_q),
    .stat ({onsw_q, flags}),
    .key  (key_q),
    .data (rd_mux)
  );

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/sac_checker.sv
module sac_checker #(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sec_tick,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              hold,
  input logic              sclr,
  input logic              force_hi,
  input logic [W-1:0]      up,
  input logic [W-1:0]      dn,
  input logic [1:0]        flags,
  input logic              irq_o,
  input logic              wake_o
);
  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !hold && !sclr && !bus_wr) |=>
      (up == $past(up) + W'(1)) && (dn == $past(dn) - W'(1)));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (hold && !sclr && !bus_wr) |=> ($stable(up) && $stable(dn)));

  p_latch_r5: assert property (@(posedge clk) disable iff (rst)
    (flags[0] && !(bus_wr && bus_addr == ADDR_W'(8'h14))) |=> flags[0]);

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(flags[0] || flags[1]));

  p_force_r9: assert property (@(posedge clk) disable iff (rst)
    force_hi |=> wake_o);

  p_swrst_r10: assert property (@(posedge clk) disable iff (rst)
    (sclr && !bus_wr) |=> (up == '0 && dn == '0));
endmodule

bind sec_alarm_ctr sac_checker #(.W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sec_tick (sec_tick),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .hold     (ctrl_q[6]),
  .sclr     (ctrl_q[4]),
  .force_hi (ctrl_q[7]),
  .up       (up_cnt),
  .dn       (dn_cnt),
  .flags    (flags),
  .irq_o    (irq_o),
  .wake_o   (wake_o)
);

// File: tb/sec_alarm_ctr_tb.sv
`timescale 1ns/1ps
module sec_alarm_ctr_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sec_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, wake_o;

  int checks = 0;
  int fails  = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #5 clk = ~clk;

  sec_alarm_ctr u_dut (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .wake_o(wake_o)
  );

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: compare read data against the scoreboard
  always @(negedge clk) begin
    if (rd_seen) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s: read got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic wr_tick(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; sec_tick = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; sec_tick = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; sec_tick = 1'b1;
      @(posedge clk); #1; sec_tick = 1'b0;
    end
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: got %b expected %b", t, act, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk(irq_o, 1'b0, "R1 irq");
    chk(wake_o, 1'b0, "R1 wake");
    rd(8'h00, 32'h0, "R1 up");
    rd(8'h04, 32'hFFFFFFFF, "R1 dn");
    rd(8'h08, 32'hFFFFFFFF, "R1 m0");
    rd(8'h0C, 32'hFFFFFFFF, "R1 m1");
    rd(8'h10, 32'h0, "R1 ctrl");
    rd(8'h14, 32'h0, "R1 stat");

    // R2 counting from a loaded value
    wr(8'h10, 32'h40);
    wr(8'h00, 32'd100);
    wr(8'h04, 32'hFFFFFFFF - 32'd100);
    wr(8'h10, 32'h00);
    tick(3);
    rd(8'h00, 32'd103, "R2 up");
    rd(8'h04, 32'hFFFFFFFF - 32'd103, "R2 dn");

    // R3 hold
    wr(8'h10, 32'h40);
    tick(2);
    rd(8'h00, 32'd103, "R3 up");
    rd(8'h04, 32'hFFFFFFFF - 32'd103, "R3 dn");

    // R5/R7 match slot 0 with interrupt enable
    wr(8'h00, 32'd10);
    wr(8'h04, 32'hFFFFFFFF - 32'd10);
    wr(8'h08, 32'd12);
    wr(8'h10, 32'h01);
    tick(2);
    idle(3);
    chk(irq_o, 1'b1, "R7 irq on slot0");
    chk(wake_o, 1'b0, "R8 no wake without enable");
    rd(8'h14, 32'h1, "R5 stat set");

    // R5 clear while equal re-latches; R6 clear after equality removed
    wr(8'h14, 32'h1);
    idle(2);
    rd(8'h14, 32'h1, "R5 relatch");
    wr(8'h08, 32'hFFFFFFFF);
    wr(8'h14, 32'h1);
    idle(2);
    chk(irq_o, 1'b0, "R6 irq dropped");
    rd(8'h14, 32'h0, "R6 cleared");

    // R8 slot 1 wake only
    wr(8'h10, 32'h08);
    wr(8'h0C, 32'd13);
    tick(1);
    idle(3);
    chk(wake_o, 1'b1, "R8 wake");
    chk(irq_o, 1'b0, "R7 slot1 irq disabled");
    rd(8'h14, 32'h6, "R8 stat onsw");
    wr(8'h10, 32'h40);
    wr(8'h0C, 32'hFFFFFFFF);
    wr(8'h14, 32'h7);
    idle(2);
    chk(wake_o, 1'b0, "R8 wake drop");
    rd(8'h14, 32'h0, "R6 clear all");

    // R9 force
    wr(8'h10, 32'hC0);
    idle(2);
    chk(wake_o, 1'b1, "R9 force");
    rd(8'h14, 32'h0, "R9 no status");
    wr(8'h10, 32'h40);
    idle(2);
    chk(wake_o, 1'b0, "R9 release");

    // R10 software clear
    wr(8'h18, 32'hB5C13F27);
    wr(8'h08, 32'h1234);
    wr(8'h10, 32'h50);
    idle(1);
    rd(8'h00, 32'h0, "R10 up");
    rd(8'h04, 32'h0, "R10 dn");
    rd(8'h08, 32'h1234, "R10 m0 kept");
    rd(8'h18, 32'hB5C13F27, "R10 key kept");
    rd(8'h10, 32'h50, "R10 ctrl kept");
    wr(8'h10, 32'h00);

    // R4 write on a tick cycle
    wr_tick(8'h00, 32'd500);
    rd(8'h00, 32'd500, "R4 up written");
    rd(8'h04, 32'hFFFFFFFF, "R4 dn ticked");

    // R12 unmapped and reserved bit
    wr(8'h1C, 32'hAAAA5555);
    wr(8'h80, 32'h12345678);
    rd(8'h1C, 32'h0, "R12 0x1C");
    rd(8'h80, 32'h0, "R12 0x80");
    rd(8'h00, 32'd500, "R12 up untouched");
    wr(8'h10, 32'h60);
    rd(8'h10, 32'h40, "R12 bit5");

    // R11 key survives reset
    @(posedge clk); #1; rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(1);
    rd(8'h18, 32'hB5C13F27, "R11 key after rst");
    rd(8'h10, 32'h0, "R11 ctrl reset");
    rd(8'h00, 32'h0, "R11 up reset");

    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule